// File: doc/BRIEF.md
# Stream Payload Packet Encapsulator

This block sits behind a datagram offload stage and turns each received payload into a packet for an internal network. The upstream stage hands over a length-first byte stream: one size beat carrying the payload byte count, then exactly that many payload bytes. The block answers with a 128-bit packet stream. Each packet is one header word, then the payload packed into 128-bit words, then one footer word.

The header reports the number of payload bytes kept and a destination value sampled from a configuration input when the size beat is taken. The footer carries a packet sequence number. The byte count alone decides where a packet ends, so the header can be sent before any payload arrives. A payload longer than 4096 bytes is cut to 256 words. Its surplus bytes are still consumed from the input and dropped, and a sticky overflow flag is raised. Backpressure on the output stalls the block without losing data.

Top module: `pkt_encap`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and ovf_flag is 0, and the first packet's footer carries sequence number 0.
- R2: An input beat accepted with in_sop=1 while idle is a size beat: in_len is the payload byte count that follows, and cfg_dest is captured at that moment for the header.
- R3: The header word has bits [12:0] equal to the number of payload bytes kept, bit 13 set when bytes were dropped, bits [31:16] equal to the captured destination, and all other bits zero.
- R4: Payload byte k (counting from 0) sits in bits [8*(k%16)+7 : 8*(k%16)] of payload word k/16; unused bytes of the last word are zero.
- R5: The footer word has bits [15:0] equal to the sequence number and all other bits zero; the number rises by one per packet.
- R6: Every packet is one header word with out_sop=1, then ceil(kept/16) payload words, then one footer word with out_eop=1; a zero-length payload gives a header directly followed by a footer, and no word has both markers set.
- R7: For in_len above 4096, only the first 4096 bytes are packed, the remaining bytes are accepted and discarded before the footer, and the header count reads 4096 with bit 13 set; for in_len equal to 4096, bit 13 is clear.
- R8: ovf_flag rises when a size beat above 4096 bytes is taken and stays set until reset.
- R9: While out_valid=1 and out_ready=0, the output word and its markers are held unchanged.
- R10: in_ready is 0 while the footer waits in the output register, and the next packet is not taken until the footer is accepted.
- R11: Beats with in_sop=0 arriving while idle are accepted and dropped without producing output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_sop | input | 1 | Beat is a size beat |
| in_len | input | 16 | Payload byte count, used on size beats |
| in_data | input | 8 | Payload byte, used on data beats |
| cfg_dest | input | 16 | Destination value placed in the header |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream takes the output word |
| out_data | output | 128 | Output packet word |
| out_sop | output | 1 | Word is a header |
| out_eop | output | 1 | Word is a footer |
| ovf_flag | output | 1 | Sticky flag for an oversized payload |

## Verification
Once the size beat is taken, the header reaches the output register at the next clock edge. A payload word follows one edge after its last byte is taken, and the footer one edge after the last payload word has been loaded. Further stalls come only from out_ready. The bench therefore builds the expected word list for each packet when it sends the size beat and compares words in order at the output handshake, so results are checked whenever they arrive rather than at a fixed cycle. Hold checks look at the cycle right after a refused word. The overflow flag is read only once the packet that set it has fully drained.

// File: rtl/pkt_encap_pkg.sv
package pkt_encap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PAY,
    ST_DROP,
    ST_FTR,
    ST_WAIT
  } enc_state_t;

  localparam int HDR_TRUNC_BIT = 13;
  localparam int HDR_DEST_LSB  = 16;
endpackage

// File: rtl/pkt_encap_packer.sv
module pkt_encap_packer #(
  parameter int BYTE_W = 8,
  parameter int LANES  = 16,
  localparam int WORD_W = BYTE_W * LANES,
  localparam int IDX_W  = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              last,
  input  logic [BYTE_W-1:0] din,
  input  logic              pop,
  output logic [WORD_W-1:0] word,
  output logic              full
);
  logic [IDX_W-1:0] idx;

  // one register per byte lane; cleared on pop so a short last word pads with zeros
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst || pop) begin
        lane_q <= '0;
      end else if (push && idx == IDX_W'(g)) begin
        lane_q <= din;
      end
    end
    assign word[g*BYTE_W +: BYTE_W] = lane_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx  <= '0;
      full <= 1'b0;
    end else if (pop) begin
      idx  <= '0;
      full <= 1'b0;
    end else if (push) begin
      if (last || idx == IDX_W'(LANES - 1)) begin
        full <= 1'b1;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pkt_encap_outreg.sv
module pkt_encap_outreg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_data,
  input  logic         ld_sop,
  input  logic         ld_eop,
  input  logic         out_ready,
  output logic         can_load,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_sop,
  output logic         out_eop
);
  assign can_load = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else if (can_load) begin
      out_valid <= ld;
      if (ld) begin
        out_data <= ld_data;
        out_sop  <= ld_sop;
        out_eop  <= ld_eop;
      end
    end
  end
endmodule

// File: rtl/pkt_encap_ctrl.sv
module pkt_encap_ctrl
  import pkt_encap_pkg::*;
#(
  parameter int LANES     = 16,
  parameter int MAX_WORDS = 256,
  parameter int LEN_W     = 16,
  parameter int DEST_W    = 16,
  parameter int SEQ_W     = 16,
  parameter int WORD_W    = 128,
  localparam int MAX_BYTES = MAX_WORDS * LANES,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic [LEN_W-1:0]  in_len,
  output logic              in_ready,
  input  logic [DEST_W-1:0] cfg_dest,
  output logic              pk_push,
  output logic              pk_last,
  input  logic              pk_full,
  output logic              pk_pop,
  input  logic [WORD_W-1:0] pk_word,
  input  logic              ol_can,
  output logic              ol_ld,
  output logic [WORD_W-1:0] ol_data,
  output logic              ol_sop,
  output logic              ol_eop,
  input  logic              ol_done,
  output logic              ovf_flag
);
  enc_state_t        state;
  logic [CNT_W-1:0]  kept_total;
  logic [CNT_W-1:0]  kept_left;
  logic [LEN_W-1:0]  excess;
  logic              trunc_q;
  logic [DEST_W-1:0] dest_q;
  logic [SEQ_W-1:0]  seq_q;

  logic              acc;
  logic              over;
  logic [CNT_W-1:0]  capped;
  logic [WORD_W-1:0] hdr_word;
  logic [WORD_W-1:0] ftr_word;

  always_comb begin
    case (state)
      ST_IDLE: in_ready = 1'b1;
      ST_PAY:  in_ready = !pk_full;
      ST_DROP: in_ready = 1'b1;
      default: in_ready = 1'b0;
    endcase
  end

  assign acc     = in_valid && in_ready;
  assign over    = in_len > LEN_W'(MAX_BYTES);
  assign capped  = over ? CNT_W'(MAX_BYTES) : CNT_W'(in_len);
  assign pk_push = acc && (state == ST_PAY);
  assign pk_last = (kept_left == CNT_W'(1));

  always_comb begin
    hdr_word = '0;
    hdr_word[CNT_W-1:0] = kept_total;
    hdr_word[HDR_TRUNC_BIT] = trunc_q;
    hdr_word[HDR_DEST_LSB +: DEST_W] = dest_q;
    ftr_word = '0;
    ftr_word[SEQ_W-1:0] = seq_q;
  end

  always_comb begin
    ol_ld   = 1'b0;
    ol_data = pk_word;
    ol_sop  = 1'b0;
    ol_eop  = 1'b0;
    pk_pop  = 1'b0;
    case (state)
      ST_HDR: begin
        ol_ld   = ol_can;
        ol_data = hdr_word;
        ol_sop  = 1'b1;
      end
      ST_PAY: begin
        if (pk_full && ol_can) begin
          ol_ld  = 1'b1;
          pk_pop = 1'b1;
        end
      end
      ST_FTR: begin
        ol_ld   = ol_can;
        ol_data = ftr_word;
        ol_eop  = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      kept_total <= '0;
      kept_left  <= '0;
      excess     <= '0;
      trunc_q    <= 1'b0;
      dest_q     <= '0;
      seq_q      <= '0;
      ovf_flag   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (acc && in_sop) begin
            kept_total <= capped;
            kept_left  <= capped;
            excess     <= in_len - LEN_W'(capped);
            trunc_q    <= over;
            dest_q     <= cfg_dest;
            if (over) ovf_flag <= 1'b1;
            state      <= ST_HDR;
          end
        end
        ST_HDR: begin
          if (ol_can) state <= (kept_total == '0) ? ST_FTR : ST_PAY;
        end
        ST_PAY: begin
          if (pk_push) kept_left <= kept_left - 1'b1;
          if (pk_pop && kept_left == '0) begin
            state <= (excess != '0) ? ST_DROP : ST_FTR;
          end
        end
        ST_DROP: begin
          if (acc) begin
            excess <= excess - 1'b1;
            if (excess == LEN_W'(1)) state <= ST_FTR;
          end
        end
        ST_FTR: begin
          if (ol_can) begin
            seq_q <= seq_q + 1'b1;
            state <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (ol_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pkt_encap.sv
module pkt_encap #(
  parameter int BYTE_W    = 8,
  parameter int LANES     = 16,
  parameter int MAX_WORDS = 256,
  parameter int LEN_W     = 16,
  parameter int DEST_W    = 16,
  parameter int SEQ_W     = 16,
  localparam int WORD_W    = BYTE_W * LANES,
  localparam int MAX_BYTES = MAX_WORDS * LANES,
  localparam int CNT_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sop,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [BYTE_W-1:0] in_data,
  input  logic [DEST_W-1:0] cfg_dest,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  output logic              ovf_flag
);
  logic              pk_push;
  logic              pk_last;
  logic              pk_full;
  logic              pk_pop;
  logic [WORD_W-1:0] pk_word;
  logic              ol_can;
  logic              ol_ld;
  logic [WORD_W-1:0] ol_data;
  logic              ol_sop;
  logic              ol_eop;
  logic              ol_done;

  assign ol_done = out_valid && out_ready;

  pkt_encap_ctrl #(
    .LANES(LANES), .MAX_WORDS(MAX_WORDS), .LEN_W(LEN_W),
    .DEST_W(DEST_W), .SEQ_W(SEQ_W), .WORD_W(WORD_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_sop(in_sop), .in_len(in_len), .in_ready(in_ready),
    .cfg_dest(cfg_dest),
    .pk_push(pk_push), .pk_last(pk_last), .pk_full(pk_full), .pk_pop(pk_pop),
    .pk_word(pk_word),
    .ol_can(ol_can), .ol_ld(ol_ld), .ol_data(ol_data), .ol_sop(ol_sop),
    .ol_eop(ol_eop), .ol_done(ol_done),
    .ovf_flag(ovf_flag)
  );

  pkt_encap_packer #(.BYTE_W(BYTE_W), .LANES(LANES)) u_packer (
    .clk(clk), .rst(rst),
    .push(pk_push), .last(pk_last), .din(in_data), .pop(pk_pop),
    .word(pk_word), .full(pk_full)
  );

  pkt_encap_outreg #(.W(WORD_W)) u_outreg (
    .clk(clk), .rst(rst),
    .ld(ol_ld), .ld_data(ol_data), .ld_sop(ol_sop), .ld_eop(ol_eop),
    .out_ready(out_ready), .can_load(ol_can),
    .out_valid(out_valid), .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop)
  );
endmodule

// File: rtl/pkt_encap_chk.sv
module pkt_encap_chk #(
  parameter int WORD_W    = 128,
  parameter int CNT_W     = 13,
  parameter int MAX_BYTES = 4096
) (
  input logic              clk,
  input logic              rst,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              out_sop,
  input logic              out_eop,
  input logic              ovf_flag
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)); // R9

  AST_FTR_BLOCKS_IN: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_eop |-> !in_ready); // R10

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag); // R8

  AST_MARKER_EXCL: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(out_sop && out_eop)); // R6

  AST_HDR_LEN_CAP: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_sop |-> out_data[CNT_W-1:0] <= CNT_W'(MAX_BYTES)); // R7
endmodule

bind pkt_encap pkt_encap_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W), .MAX_BYTES(MAX_BYTES)) u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
  .out_eop(out_eop), .ovf_flag(ovf_flag)
);

// File: tb/pkt_encap_bench.sv
module pkt_encap_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic         in_sop = 1'b0;
  logic [15:0]  in_len = '0;
  logic [7:0]   in_data = '0;
  logic [15:0]  cfg_dest = '0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;
  logic         out_sop;
  logic         out_eop;
  logic         ovf_flag;

  int checks = 0;
  int errors = 0;
  int rdy_mode = 0;
  int seq_exp = 0;
  logic [129:0] exp_q[$];
  logic [7:0]   pl [0:4199];

  always #4 clk = ~clk;

  pkt_encap u_pkt_encap (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sop(in_sop), .in_len(in_len), .in_data(in_data), .cfg_dest(cfg_dest),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop), .ovf_flag(ovf_flag)
  );

  task automatic chk(bit ok, string req, logic [129:0] act, logic [129:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [127:0] hdr_word(int kept, bit trunc, logic [15:0] dest);
    logic [127:0] w = '0;
    w[12:0]  = 13'(kept);
    w[13]    = trunc;
    w[31:16] = dest;
    return w;
  endfunction

  task automatic beat(bit sop, logic [15:0] len, logic [7:0] d, bit gaps);
    if (gaps && ($urandom % 5 == 0)) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    in_sop   = sop;
    in_len   = len;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // R2 R3 R4 R5 R6 R7: expected words are queued before the size beat is driven
  task automatic send_pkt(int len, bit gaps);
    logic [15:0]  dest = 16'($urandom);
    int           kept = (len > 4096) ? 4096 : len;
    logic [127:0] w = '0;
    for (int b = 0; b < len; b++) pl[b] = 8'($urandom);
    exp_q.push_back({1'b1, 1'b0, hdr_word(kept, len > 4096, dest)});
    for (int b = 0; b < kept; b++) begin
      w[(b % 16) * 8 +: 8] = pl[b];
      if ((b % 16) == 15 || b == kept - 1) begin
        exp_q.push_back({1'b0, 1'b0, w});
        w = '0;
      end
    end
    exp_q.push_back({1'b0, 1'b1, 112'd0, 16'(seq_exp)});
    seq_exp++;
    cfg_dest = dest;
    beat(1'b1, 16'(len), 8'h00, gaps);
    cfg_dest = ~dest;
    for (int b = 0; b < len; b++) beat(1'b0, 16'h0, pl[b], gaps);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // output monitor and ready driver
  initial begin
    bit           stall_prev = 1'b0;
    logic [129:0] hold = '0;
    logic [129:0] e;
    bit           r;
    string        req;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      if (stall_prev)
        chk(out_valid && {out_sop, out_eop, out_data} == hold, "R9 hold",
            {out_sop, out_eop, out_data}, hold);
      r = (rdy_mode == 0) ? 1'b1 : ($urandom % 3 != 0);
      out_ready = r;
      stall_prev = out_valid && !r;
      hold = {out_sop, out_eop, out_data};
      if (out_valid && r) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected word", {out_sop, out_eop, out_data}, '0);
        end else begin
          e = exp_q.pop_front();
          req = e[129] ? "R3 header" : (e[128] ? "R5 footer" : "R4 payload");
          chk({out_sop, out_eop, out_data} == e, req, {out_sop, out_eop, out_data}, e);
        end
        if (out_eop) chk(!in_ready, "R10 input blocked", 130'(in_ready), 130'd0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", 130'(out_valid), 130'd0);
    chk(in_ready == 1'b1, "R1 in_ready", 130'(in_ready), 130'd1);
    chk(ovf_flag == 1'b0, "R1 ovf_flag", 130'(ovf_flag), 130'd0);

    rdy_mode = 0;
    send_pkt(16, 1'b0);   // R4 exact word
    send_pkt(1, 1'b0);    // R4 padding
    send_pkt(0, 1'b0);    // R6 empty payload
    send_pkt(17, 1'b0);
    drain();
    // R11 stray data beats while idle
    for (int i = 0; i < 3; i++) beat(1'b0, 16'h0, 8'hA5, 1'b0);
    drain();
    chk(out_valid == 1'b0, "R11 no output", 130'(out_valid), 130'd0);
    send_pkt(5, 1'b0);

    rdy_mode = 1;
    for (int i = 0; i < 20; i++) send_pkt(1 + int'($urandom % 80), 1'b1);
    drain();
    chk(ovf_flag == 1'b0, "R8 no overflow yet", 130'(ovf_flag), 130'd0);
    send_pkt(4096, 1'b1); // R7 exact limit
    drain();
    chk(ovf_flag == 1'b0, "R7 limit not overflow", 130'(ovf_flag), 130'd0);
    send_pkt(4100, 1'b1); // R7 truncation
    drain();
    chk(ovf_flag == 1'b1, "R8 overflow set", 130'(ovf_flag), 130'd1);
    send_pkt(33, 1'b1);
    drain();
    chk(ovf_flag == 1'b1, "R8 overflow sticky", 130'(ovf_flag), 130'd1);
    chk(exp_q.size() == 0, "R6 all words seen", 130'(exp_q.size()), 130'd0);
    chk(in_ready == 1'b1, "R10 ready after footer", 130'(in_ready), 130'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule